// File: doc/BRIEF.md
# Cascadable Serial Configuration Bitstream Reader

This block is the read side of a serial configuration memory. It holds a bit array of parameterised depth and, while selected, shifts one stored bit per clock out to a programmable logic device that is loading its configuration. An internal position counter chooses the bit on the output. It advances on every rising clock edge while the device is selected. It returns to zero when the combined reset/output-enable pin is at its reset level.

Which level of that pin means reset is set by a stored polarity bit. The host can therefore drive the pin from a reset line of either sense with no inverter. When the last stored bit has been shifted out, the block turns off its own data output and pulls its cascade output low. That output feeds the chip-enable of the next device in a chain, so several devices present one unbroken bitstream.

The tri-state data pin is modelled as a data value plus a drive-enable. A serial-enable input selects read mode. When it is low, the part is treated as being programmed and the read path stays idle. A synchronous load port fills the array and writes the polarity bit for test.

Top module: `cfg_bitstream_reader`

## Requirements
- R1: After the synchronous reset, the position counter is 0 and the polarity bit is 0. `dout_oe` is 0 and `ce_out_n` is 1 while `ce_n` is high. With polarity 0 and `rstoe` low, the device drives as soon as `ce_n` goes low.
- R2: `dout_oe` is 1 only when all of the following hold: `ser_en`=1, `ce_n`=0, `rstoe` is at its output-enable level, and the counter is below DEPTH. When `dout_oe` is 0, `dout` is 0.
- R3: While driving, `dout` equals the stored bit at the counter's address. Each rising edge with `ser_en`=1, `ce_n`=0 and `rstoe` not at its reset level advances the counter by one.
- R4: A rising edge with `ser_en`=1 and `rstoe` at its reset level clears the counter to 0, whatever `ce_n` is. The next read starts at bit 0.
- R5: The polarity encoding works as follows. With polarity 0, `rstoe`=1 is reset and `rstoe`=0 enables output. With polarity 1, `rstoe`=0 is reset and `rstoe`=1 enables output. A rising edge with `pol_we`=1 stores `pol_val`.
- R6: While `ce_n`=1, the counter holds its value and `dout_oe` is 0 for either `rstoe` level. Reading resumes at the held bit when `ce_n` returns low.
- R7: After the edge that moves past the last bit, the counter stays at DEPTH until a reset. `dout_oe` is 0, and `ce_out_n` is 0 while `ce_n`=0. A chained device therefore continues the stream with its bit 0 on the next cycle.
- R8: When the counter is at DEPTH, `ce_out_n` follows `ce_n`. At any other count, `ce_out_n` is 1, so a reset edge returns it high.
- R9: While `ser_en`=0, the counter neither advances nor clears, `dout_oe` is 0 and `ce_out_n` is 1.
- R10: A rising edge with `ld_we`=1 writes `ld_bit` into the array at address `ld_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read and load clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_en | input | 1 | High selects read mode; low idles the read path |
| ce_n | input | 1 | Active-low chip enable |
| rstoe | input | 1 | Combined reset/output-enable pin, sense set by the polarity bit |
| pol_we | input | 1 | Write strobe for the polarity bit |
| pol_val | input | 1 | Polarity value to store |
| ld_we | input | 1 | Array write strobe |
| ld_addr | input | AW | Array write address |
| ld_bit | input | 1 | Array write data |
| dout | output | 1 | Serial data value (0 when not driving) |
| dout_oe | output | 1 | Drive-enable of the data pin; 0 means high-impedance |
| ce_out_n | output | 1 | Active-low cascade enable for the next device |

## Verification
A counter that is off by one shows at `dout` as a shifted stream on the very next sampled bit. Two chained instances make a late or early end-of-array flag visible: there is either a cycle with no driver or a cycle with two. Both are caught at the boundary between instance A's last bit and instance B's first. A polarity bit that was stored wrongly, or a reset that is missed, shows within one cycle: output drive appears at the wrong `rstoe` level, or bit 0 fails to reappear after a reset pulse. Random stretches of chip-enable, serial-enable and reset activity are compared cycle by cycle against a bench model of both counters.

// File: rtl/scr_pkg.sv
package scr_pkg;

    // Decoded control for one clock of the read path.
    typedef struct packed {
        logic clr;   // return the position counter to zero
        logic adv;   // step the position counter
        logic sel;   // device selected with output enabled
    } scr_ctrl_t;

    // True when the pin sits at the level that means reset.
    function automatic logic pin_is_reset(input logic pin, input logic pol);
        return pol ? ~pin : pin;
    endfunction

endpackage

// File: rtl/scr_pin_ctrl.sv
module scr_pin_ctrl
    import scr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      pol_we,
    input  logic      pol_val,
    input  logic      ser_en,
    input  logic      ce_n,
    input  logic      rstoe,
    output scr_ctrl_t ctrl,
    output logic      pol_q
);

    logic at_reset;

    always_ff @(posedge clk) begin
        if (rst)         pol_q <= 1'b0;
        else if (pol_we) pol_q <= pol_val;
    end

    always_comb begin
        at_reset  = pin_is_reset(rstoe, pol_q);
        ctrl.clr  = ser_en & at_reset;
        ctrl.sel  = ser_en & ~ce_n & ~at_reset;
        ctrl.adv  = ctrl.sel;
    end

    // R5: the stored polarity only changes on a write strobe
    a_r5_pol_hold: assert property (@(posedge clk) disable iff (rst)
        !pol_we |=> pol_q == $past(pol_q));
    a_r5_pol_load: assert property (@(posedge clk) disable iff (rst)
        pol_we |=> pol_q == $past(pol_val));

endmodule

// File: rtl/scr_addr_ctr.sv
module scr_addr_ctr #(
    parameter int unsigned DEPTH = 2048,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          adv,
    output logic [CW-1:0] cnt,
    output logic          done
);

    localparam logic [CW-1:0] LAST = CW'(DEPTH);

    assign done = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst)               cnt <= '0;
        else if (clr)          cnt <= '0;
        else if (adv && !done) cnt <= cnt + 1'b1;
    end

    // R3: one step per selected edge
    a_r3_step: assert property (@(posedge clk) disable iff (rst)
        (adv && !clr && !done) |=> cnt == CW'($past(cnt) + 1'b1));
    // R4: reset level clears the position
    a_r4_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> cnt == '0);
    // R6 / R9: no step, no clear -> position held
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (!adv && !clr) |=> $stable(cnt));
    // R7: saturation at the end of the array
    a_r7_saturate: assert property (@(posedge clk) disable iff (rst)
        (done && !clr) |=> done);
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

endmodule

// File: rtl/scr_bit_array.sv
module scr_bit_array #(
    parameter int unsigned DEPTH = 2048,
    localparam int unsigned AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_we,
    input  logic [AW-1:0] ld_addr,
    input  logic          ld_bit,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_bit
);

    logic [DEPTH-1:0] mem;

    always_ff @(posedge clk) begin
        if (ld_we) mem[ld_addr] <= ld_bit;
    end

    assign rd_bit = mem[rd_addr];

    // R10: a write lands at its address
    a_r10_write: assert property (@(posedge clk) disable iff (rst)
        ld_we |=> mem[$past(ld_addr)] == $past(ld_bit));

endmodule

// File: rtl/cfg_bitstream_reader.sv
module cfg_bitstream_reader
    import scr_pkg::*;
#(
    parameter int unsigned DEPTH = 2048,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ser_en,
    input  logic          ce_n,
    input  logic          rstoe,
    input  logic          pol_we,
    input  logic          pol_val,
    input  logic          ld_we,
    input  logic [AW-1:0] ld_addr,
    input  logic          ld_bit,
    output logic          dout,
    output logic          dout_oe,
    output logic          ce_out_n
);

    scr_ctrl_t     ctrl;
    logic          pol_q;
    logic [CW-1:0] cnt;
    logic          done;
    logic          rd_bit;
    logic          drive;

    scr_pin_ctrl u_pin (
        .clk     (clk),
        .rst     (rst),
        .pol_we  (pol_we),
        .pol_val (pol_val),
        .ser_en  (ser_en),
        .ce_n    (ce_n),
        .rstoe   (rstoe),
        .ctrl    (ctrl),
        .pol_q   (pol_q)
    );

    scr_addr_ctr #(.DEPTH(DEPTH)) u_ctr (
        .clk  (clk),
        .rst  (rst),
        .clr  (ctrl.clr),
        .adv  (ctrl.adv),
        .cnt  (cnt),
        .done (done)
    );

    scr_bit_array #(.DEPTH(DEPTH)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .ld_we   (ld_we),
        .ld_addr (ld_addr),
        .ld_bit  (ld_bit),
        .rd_addr (cnt[AW-1:0]),
        .rd_bit  (rd_bit)
    );

    assign drive    = ctrl.sel & ~done;
    assign dout_oe  = drive;
    assign dout     = drive & rd_bit;
    assign ce_out_n = ~(ser_en & ~ce_n & done);

    // R2: drive needs read mode and chip enable
    a_r2_drive_sel: assert property (@(posedge clk) disable iff (rst)
        dout_oe |-> (ser_en && !ce_n));
    // R6: chip enable high keeps the pin released
    a_r6_standby: assert property (@(posedge clk) disable iff (rst)
        ce_n |-> !dout_oe);
    // R7: pin released once the array is exhausted
    a_r7_off_after_last: assert property (@(posedge clk) disable iff (rst)
        done |-> !dout_oe);
    // R8: cascade stays inactive before the end
    a_r8_ceo_idle: assert property (@(posedge clk) disable iff (rst)
        !done |-> ce_out_n);
    // R9: programming mode releases everything
    a_r9_idle: assert property (@(posedge clk) disable iff (rst)
        !ser_en |-> (!dout_oe && ce_out_n));

endmodule

// File: tb/cfg_bitstream_reader_bench.sv
`timescale 1ns/1ps
module cfg_bitstream_reader_bench;

    localparam int D  = 64;
    localparam int AW = $clog2(D);

    logic clk = 1'b0;
    logic rst, ser_en, ce_n, rstoe, pol_we, pol_val;
    logic ld_we_a, ld_we_b, ld_bit;
    logic [AW-1:0] ld_addr;
    logic dout_a, oe_a, ceo_a, dout_b, oe_b, ceo_b;

    always #2.5 clk = ~clk;

    cfg_bitstream_reader #(.DEPTH(D)) u_cfg_bitstream_reader (
        .clk(clk), .rst(rst), .ser_en(ser_en), .ce_n(ce_n), .rstoe(rstoe),
        .pol_we(pol_we), .pol_val(pol_val), .ld_we(ld_we_a), .ld_addr(ld_addr),
        .ld_bit(ld_bit), .dout(dout_a), .dout_oe(oe_a), .ce_out_n(ceo_a));

    cfg_bitstream_reader #(.DEPTH(D)) u_cfg_bitstream_reader_nxt (
        .clk(clk), .rst(rst), .ser_en(ser_en), .ce_n(ceo_a), .rstoe(rstoe),
        .pol_we(pol_we), .pol_val(pol_val), .ld_we(ld_we_b), .ld_addr(ld_addr),
        .ld_bit(ld_bit), .dout(dout_b), .dout_oe(oe_b), .ce_out_n(ceo_b));

    int n_chk = 0;
    int n_fail = 0;

    // bench model
    int ca, cb;
    bit pol_m;
    bit pat_a [D];
    bit pat_b [D];

    function automatic bit m_rst(input logic pin);
        return pol_m ? !pin : pin;
    endfunction
    function automatic logic lvl_oe();
        return pol_m ? 1'b1 : 1'b0;
    endfunction
    function automatic logic lvl_rs();
        return pol_m ? 1'b0 : 1'b1;
    endfunction
    function automatic bit e_ceo_a();
        return !(ser_en && !ce_n && ca == D);
    endfunction
    function automatic bit e_oe_a();
        return ser_en && !ce_n && !m_rst(rstoe) && ca < D;
    endfunction
    function automatic bit e_ceo_b();
        return !(ser_en && !e_ceo_a() && cb == D);
    endfunction
    function automatic bit e_oe_b();
        return ser_en && !e_ceo_a() && !m_rst(rstoe) && cb < D;
    endfunction

    task automatic chk(input logic act, input logic exp, input string tag, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_all();
        chk(oe_a, e_oe_a(), "R2", "oe_a");
        chk(oe_b, e_oe_b(), "R2", "oe_b");
        chk(dout_a, e_oe_a() ? pat_a[ca] : 1'b0, "R3", "dout_a");
        chk(dout_b, e_oe_b() ? pat_b[cb] : 1'b0, "R3", "dout_b");
        chk(ceo_a, e_ceo_a(), "R8", "ceo_a");
        chk(ceo_b, e_ceo_b(), "R8", "ceo_b");
    endtask

    task automatic model_edge();
        bit r, ceb;
        if (rst) begin
            ca = 0; cb = 0; pol_m = 1'b0;
            return;
        end
        r   = ser_en && m_rst(rstoe);
        ceb = e_ceo_a();
        if (ser_en) begin
            if (r) begin ca = 0; cb = 0; end
            else begin
                if (!ce_n && ca < D) ca++;
                if (!ceb && cb < D) cb++;
            end
        end
        if (ld_we_a) pat_a[ld_addr] = ld_bit;
        if (ld_we_b) pat_b[ld_addr] = ld_bit;
        if (pol_we) pol_m = pol_val;
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_all();
    endtask

    task automatic rst_pulse();
        rstoe = lvl_rs();
        step();
        rstoe = lvl_oe();
        #0.1;
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic comb, expb, nb;
        void'($urandom(32'h5eed_c0de));
        rst = 1; ser_en = 1; ce_n = 1; rstoe = 0; pol_we = 0; pol_val = 0;
        ld_we_a = 0; ld_we_b = 0; ld_bit = 0; ld_addr = '0;
        ca = 0; cb = 0; pol_m = 0;
        repeat (3) step();
        rst = 0;
        #0.1;
        chk(oe_a, 1'b0, "R1", "oe_a after reset");
        chk(ceo_a, 1'b1, "R1", "ceo_a after reset");
        chk(dout_a, 1'b0, "R1", "dout_a after reset");

        // R10: fill both arrays with a random pattern
        for (int i = 0; i < D; i++) begin
            ld_addr = AW'(i); ld_bit = 1'($urandom); ld_we_a = 1; step();
            ld_we_a = 0;
            ld_bit = 1'($urandom); ld_we_b = 1; step();
            ld_we_b = 0;
        end

        // R1: default polarity, low pin enables output
        ce_n = 0; rstoe = 0;
        #0.1;
        chk(oe_a, 1'b1, "R1", "default polarity drive");
        chk(dout_a, pat_a[0], "R10", "first loaded bit");

        // R3 / R7: full concatenated stream through the chain
        for (int i = 0; i < 2 * D + 3; i++) begin
            comb = oe_a ? dout_a : (oe_b ? dout_b : 1'b0);
            chk(oe_a | oe_b, (i < 2 * D), "R7", "stream driver present");
            chk(oe_a & oe_b, 1'b0, "R2", "single driver");
            if (i < 2 * D) begin
                expb = (i < D) ? pat_a[i] : pat_b[i - D];
                chk(comb, expb, "R3", "stream bit");
            end
            if (i == D) begin
                chk(oe_a, 1'b0, "R7", "first device off after last bit");
                chk(ceo_a, 1'b0, "R7", "cascade low after last bit");
                chk(dout_b, pat_b[0], "R7", "next device bit 0");
            end
            step();
        end

        // R8: cascade follows chip enable while exhausted
        ce_n = 1; #0.1;
        chk(ceo_a, 1'b1, "R8", "ceo follows ce high");
        ce_n = 0; #0.1;
        chk(ceo_a, 1'b0, "R8", "ceo follows ce low");

        // R4: reset level restarts the read
        rst_pulse();
        chk(ceo_a, 1'b1, "R8", "ceo high after reset");
        chk(dout_a, pat_a[0], "R4", "bit 0 after reset");
        repeat (20) step();
        chk(dout_a, pat_a[20], "R3", "bit 20 mid-stream");
        rst_pulse();
        chk(dout_a, pat_a[0], "R4", "mid-stream restart at bit 0");

        // R4: reset also applies with chip enable high
        repeat (5) step();
        ce_n = 1; rst_pulse(); ce_n = 0; #0.1;
        chk(dout_a, pat_a[0], "R4", "reset while deselected");

        // R6: standby freezes the position
        repeat (7) step();
        ce_n = 1;
        for (int k = 0; k < 5; k++) begin
            rstoe = 1'(k & 1) ? lvl_rs() : lvl_oe();
            #0.1;
            chk(oe_a, 1'b0, "R6", "standby no drive");
            @(posedge clk);
            model_edge();
            @(negedge clk);
        end
        // odd k cleared, so reset deliberately ended last at k=3; re-read model
        rstoe = lvl_oe(); ce_n = 0; #0.1;
        chk(dout_a, pat_a[ca], "R6", "resume at held bit");
        rst_pulse();
        repeat (7) step();
        ce_n = 1;
        repeat (5) step();
        ce_n = 0; #0.1;
        chk(dout_a, pat_a[7], "R6", "resume at bit 7");

        // R10: rewrite bit 7 and read it back
        ce_n = 1; nb = !pat_a[7];
        ld_addr = AW'(7); ld_bit = nb; ld_we_a = 1; step(); ld_we_a = 0;
        ce_n = 0; #0.1;
        chk(dout_a, nb, "R10", "rewritten bit");

        // R9: programming mode idles the read path
        ser_en = 0; rstoe = lvl_rs();
        for (int k = 0; k < 4; k++) begin
            step();
            chk(oe_a, 1'b0, "R9", "no drive when serial disabled");
            chk(ceo_a, 1'b1, "R9", "ceo high when serial disabled");
        end
        ser_en = 1; rstoe = lvl_oe(); #0.1;
        chk(dout_a, nb, "R9", "position kept through programming mode");

        // R5: inverted polarity
        ce_n = 1; pol_we = 1; pol_val = 1; step(); pol_we = 0;
        rstoe = 1; ce_n = 0; #0.1;
        chk(oe_a, 1'b1, "R5", "high pin enables with polarity 1");
        chk(dout_a, nb, "R5", "position kept through polarity write");
        rstoe = 0; #0.1;
        chk(oe_a, 1'b0, "R5", "low pin is reset with polarity 1");
        step();
        rstoe = 1; #0.1;
        chk(dout_a, pat_a[0], "R5", "low pin cleared with polarity 1");

        // random phase
        for (int k = 0; k < 4000; k++) begin
            ser_en = ($urandom % 16) != 0;
            ce_n   = ($urandom % 8) == 0;
            rstoe  = (($urandom % 40) == 0) ? lvl_rs() : lvl_oe();
            if (($urandom % 500) == 0) begin
                pol_we = 1; pol_val = 1'($urandom);
            end
            step();
            pol_we = 0;
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule